// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog peripheral sitting on a simple memory-mapped register bus. A 12-bit down-counter is advanced by a slow, free-running counter clock. That clock is presented to the block as a single-cycle enable, `cnt_tick`, which is synchronous to the bus clock. The enable first passes through a programmable power-of-two prescaler. When the counter underflows, the block drives `wdg_rst` for a fixed number of bus cycles, reloads the counter and keeps running. Once started, software cannot stop it. Only a reset returns it to idle.

All control goes through a key register. One key value starts the counter, one reloads it, one unlocks the configuration registers, and any other value locks them again. The prescaler, reload and early-warning settings are written into bus-side shadow copies. Each copy is then moved into the counter domain after a fixed number of counter ticks, and a per-register pending flag in the status word shows the move in progress. An early-warning comparator sets a sticky flag, and `early_irq`, when the counter steps down onto a programmed compare value. Writing a new compare value also refreshes the counter.

Top module: `wdg_indep_top`

## Requirements
- R1: After reset the block is locked and idle. Status reads 0, prescaler reads 0, reload reads 0xFFF, early-warning control reads 0, and `wdg_rst` and `early_irq` are low.
- R2: Writing the full 32-bit word 0x00005555 to the key register (offset 0x00) unlocks configuration. Any other key word locks it. Writes to prescaler (0x04), reload (0x08) or early-warning fields (0x14) while locked leave their readback unchanged.
- R3: Writing 0x0000CCCC to the key register sets the running bit (status bit 8). No later key word clears it, and the counter is loaded from the effective reload value at the next counter tick.
- R4: Prescaler code n (bits 3:0) advances the counter once every 4·2^n counter ticks. Codes above 8 act as 8, which gives divide-by-1024.
- R5: A counter loaded with reload value R underflows (R+1) prescaled steps later. `wdg_rst` is then high for exactly RST_CYCLES bus cycles, starting the cycle after the underflow, and the counter reloads and keeps counting.
- R6: Writing 0x0000AAAA to the key register reloads the counter at the next counter tick, so periodic reloads keep `wdg_rst` low.
- R7: An accepted write to prescaler, reload or early-warning control sets status bit 0, 1 or 3 respectively. The bit clears, and the new value takes effect, at the SYNC_TICKS-th counter tick after the write. Status bit 2 always reads 0.
- R8: A write to a configuration register whose pending bit is set is ignored.
- R9: When the early warning is enabled (control bit 15) and the counter steps down to the compare value (control bits 11:0), status bit 15 and `early_irq` become 1 and stay set until cleared.
- R10: Writing 1 to bit 15 of the interrupt-clear register (0x18), or to bit 14 of the early-warning control register, clears the early flag. Both work while locked, and a locked control write changes no other field.
- R11: An accepted early-warning control write whose compare value differs from the current one also reloads the counter. A write with an unchanged compare value does not.
- R12: The version register (0x3F4) returns the REVISION parameter in bits 7:0. The key and interrupt-clear registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | One-cycle enable marking each counter-clock edge |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally during a selected read |
| early_irq | output | 1 | Sticky early-warning interrupt |
| wdg_rst | output | 1 | Reset pulse issued on counter underflow |

## Verification
The bench builds the block with RST_CYCLES = 5 and the default SYNC_TICKS = 2 and 12-bit counter, and it asserts `cnt_tick` every second bus clock. With a reload of 3 or 7 and prescaler code 0, an underflow comes every 32 or 64 bus cycles. Many expiry periods, early-warning hits and clears, and refresh races therefore fit in a short run. The same setting lets a full divide-by-1024 period (8192 cycles) be measured between two reset pulses, which exercises the clamped prescaler codes.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int unsigned ADDR_W       = 12;
  localparam int unsigned PRE_W        = 4;
  localparam int unsigned MAX_PRE_CODE = 8;
  localparam int unsigned PRE_CNT_W    = $clog2(4 << MAX_PRE_CODE);

  localparam logic [ADDR_W-1:0] OFS_KEY  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_PRE  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_RLD  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_EWC  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_ICR  = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_VER  = 12'h3F4;

  typedef enum logic [1:0] {
    KEY_LOCK   = 2'd0,
    KEY_START  = 2'd1,
    KEY_RELOAD = 2'd2,
    KEY_UNLOCK = 2'd3
  } key_cmd_e;

  function automatic key_cmd_e decode_key(input logic [31:0] word);
    case (word)
      32'h0000_CCCC: return KEY_START;
      32'h0000_AAAA: return KEY_RELOAD;
      32'h0000_5555: return KEY_UNLOCK;
      default:       return KEY_LOCK;
    endcase
  endfunction

  // Terminal value of the prescaler counter: divide by 4 * 2^code, code clamped.
  function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [PRE_W-1:0] code);
    logic [PRE_W-1:0] c;
    c = (code > PRE_W'(MAX_PRE_CODE)) ? PRE_W'(MAX_PRE_CODE) : code;
    return PRE_CNT_W'((32'd4 << c) - 32'd1);
  endfunction

endpackage

// File: rtl/wdg_xfer.sv
module wdg_xfer #(
  parameter int unsigned    W          = 12,
  parameter int unsigned    SYNC_TICKS = 2,
  parameter logic [W-1:0]   RST_VAL    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] shadow,
  output logic [W-1:0] eff,
  output logic         pend
);
  localparam int unsigned TW = $clog2(SYNC_TICKS + 1);

  logic [TW-1:0] seen_q;
  logic          accept;
  logic          land;

  assign accept = wr_en && !pend;
  assign land   = pend && tick && (seen_q == TW'(SYNC_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RST_VAL;
      eff    <= RST_VAL;
      pend   <= 1'b0;
      seen_q <= '0;
    end else if (accept) begin
      shadow <= wr_val;
      pend   <= 1'b1;
      seen_q <= '0;
    end else if (land) begin
      eff    <= shadow;
      pend   <= 1'b0;
      seen_q <= '0;
    end else if (pend && tick) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  // R7
  pend_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !tick |=> pend);
  // R7
  land_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> eff == shadow);
  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && wr_en |=> $stable(shadow));

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned SYNC_TICKS = 2,
  parameter logic [7:0]  REVISION   = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              ew_hit,
  output logic [31:0]       bus_rdata,
  output logic              running,
  output logic              refresh_req,
  output logic [PRE_W-1:0]  pre_code_eff,
  output logic [CNT_W-1:0]  rld_eff,
  output logic              ew_en_eff,
  output logic [CNT_W-1:0]  ew_cmp_eff,
  output logic              ew_flag
);
  localparam int unsigned EW_W = CNT_W + 1;

  logic wr_key, wr_pre, wr_rld, wr_ewc, wr_icr;
  logic unlocked_q;
  key_cmd_e key_cmd;

  logic [PRE_W-1:0] pre_sh;
  logic [CNT_W-1:0] rld_sh;
  logic [EW_W-1:0]  ewc_sh, ewc_eff;
  logic pre_pend, rld_pend, ewc_pend;
  logic ew_change, ew_clr;

  assign wr_key  = bus_sel && bus_wr && (bus_addr == OFS_KEY);
  assign wr_pre  = bus_sel && bus_wr && (bus_addr == OFS_PRE);
  assign wr_rld  = bus_sel && bus_wr && (bus_addr == OFS_RLD);
  assign wr_ewc  = bus_sel && bus_wr && (bus_addr == OFS_EWC);
  assign wr_icr  = bus_sel && bus_wr && (bus_addr == OFS_ICR);
  assign key_cmd = decode_key(bus_wdata);

  wdg_xfer #(.W(PRE_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('0)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_pre && unlocked_q), .wr_val(bus_wdata[PRE_W-1:0]),
    .shadow(pre_sh), .eff(pre_code_eff), .pend(pre_pend));

  wdg_xfer #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL({CNT_W{1'b1}})) u_rld (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_rld && unlocked_q), .wr_val(bus_wdata[CNT_W-1:0]),
    .shadow(rld_sh), .eff(rld_eff), .pend(rld_pend));

  wdg_xfer #(.W(EW_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('0)) u_ewc (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_ewc && unlocked_q), .wr_val({bus_wdata[15], bus_wdata[CNT_W-1:0]}),
    .shadow(ewc_sh), .eff(ewc_eff), .pend(ewc_pend));

  assign ew_en_eff  = ewc_eff[CNT_W];
  assign ew_cmp_eff = ewc_eff[CNT_W-1:0];

  assign ew_change = wr_ewc && unlocked_q && !ewc_pend &&
                     (bus_wdata[CNT_W-1:0] != ewc_sh[CNT_W-1:0]);
  assign refresh_req = ew_change ||
                       (wr_key && (key_cmd == KEY_START || key_cmd == KEY_RELOAD));
  assign ew_clr = (wr_icr && bus_wdata[15]) || (wr_ewc && bus_wdata[14]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      running    <= 1'b0;
      ew_flag    <= 1'b0;
    end else begin
      if (wr_key) unlocked_q <= (key_cmd == KEY_UNLOCK);
      if (wr_key && key_cmd == KEY_START) running <= 1'b1;
      if (ew_hit)      ew_flag <= 1'b1;
      else if (ew_clr) ew_flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_PRE:  bus_rdata[PRE_W-1:0] = pre_sh;
        OFS_RLD:  bus_rdata[CNT_W-1:0] = rld_sh;
        OFS_STAT: begin
          bus_rdata[0]  = pre_pend;
          bus_rdata[1]  = rld_pend;
          bus_rdata[3]  = ewc_pend;
          bus_rdata[8]  = running;
          bus_rdata[15] = ew_flag;
        end
        OFS_EWC: begin
          bus_rdata[15]        = ewc_sh[CNT_W];
          bus_rdata[CNT_W-1:0] = ewc_sh[CNT_W-1:0];
        end
        OFS_VER:  bus_rdata[7:0] = REVISION;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R2
  locked_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pre && !unlocked_q |=> $stable(pre_sh));
  // R2
  locked_ewc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ewc && !unlocked_q |=> $stable(ewc_sh));
  // R3
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
  // R9
  flag_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ew_flag) |-> $past(ew_en_eff));
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ew_clr && !ew_hit |=> !ew_flag);

endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             running,
  input  logic             refresh_req,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [CNT_W-1:0] rld_val,
  input  logic             ew_en,
  input  logic [CNT_W-1:0] ew_cmp,
  output logic             ew_hit,
  output logic             wdg_rst
);
  localparam int unsigned RW = $clog2(RST_CYCLES + 1);

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - 1'b1;
  endfunction

  logic [PRE_CNT_W-1:0] pre_q, pre_lim;
  logic [CNT_W-1:0]     cnt_q;
  logic                 ref_pend_q;
  logic [RW-1:0]        pulse_q, since_q;
  logic                 do_ref, pstick, expire;

  assign pre_lim = pre_limit(pre_code);
  assign do_ref  = tick && (ref_pend_q || refresh_req);
  assign pstick  = tick && running && !(ref_pend_q || refresh_req) && (pre_q >= pre_lim);
  assign expire  = pstick && (cnt_q == '0);
  assign ew_hit  = pstick && (cnt_q != '0) && ew_en && (step_down(cnt_q) == ew_cmp);
  assign wdg_rst = (pulse_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q      <= '0;
      cnt_q      <= {CNT_W{1'b1}};
      ref_pend_q <= 1'b0;
    end else if (tick) begin
      ref_pend_q <= 1'b0;
      if (do_ref) begin
        cnt_q <= rld_val;
        pre_q <= '0;
      end else if (running) begin
        if (pstick) begin
          pre_q <= '0;
          cnt_q <= expire ? rld_val : step_down(cnt_q);
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end else if (refresh_req) begin
      ref_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
      since_q <= RW'(RST_CYCLES);
    end else begin
      if (expire)              pulse_q <= RW'(RST_CYCLES);
      else if (pulse_q != '0)  pulse_q <= pulse_q - 1'b1;
      if (expire)                          since_q <= '0;
      else if (since_q != RW'(RST_CYCLES)) since_q <= since_q + 1'b1;
    end
  end

  // R4
  count_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R3
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !do_ref |=> $stable(cnt_q));
  // R5
  pulse_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst |-> since_q < RW'(RST_CYCLES));
  // R5
  pulse_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    since_q < RW'(RST_CYCLES) |-> wdg_rst);

endmodule

// File: rtl/wdg_indep_top.sv
module wdg_indep_top
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned SYNC_TICKS = 2,
  parameter int unsigned RST_CYCLES = 16,
  parameter logic [7:0]  REVISION   = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnt_tick,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        early_irq,
  output logic        wdg_rst
);
  logic             running, refresh_req, ew_en_eff, ew_hit, ew_flag;
  logic [PRE_W-1:0] pre_code_eff;
  logic [CNT_W-1:0] rld_eff, ew_cmp_eff;

  wdg_regs #(.CNT_W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .REVISION(REVISION)) u_regs (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ew_hit(ew_hit), .bus_rdata(bus_rdata), .running(running),
    .refresh_req(refresh_req), .pre_code_eff(pre_code_eff), .rld_eff(rld_eff),
    .ew_en_eff(ew_en_eff), .ew_cmp_eff(ew_cmp_eff), .ew_flag(ew_flag));

  wdg_core #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .running(running),
    .refresh_req(refresh_req), .pre_code(pre_code_eff), .rld_val(rld_eff),
    .ew_en(ew_en_eff), .ew_cmp(ew_cmp_eff), .ew_hit(ew_hit), .wdg_rst(wdg_rst));

  assign early_irq = ew_flag;

endmodule

// File: tb/sim_wdg_indep_top.sv
module sim_wdg_indep_top;
  import wdg_pkg::*;

  localparam int RSTC = 5;
  localparam int SYNC = 2;
  localparam logic [7:0] REV = 8'h40;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic        sel = 1'b1, wr = 1'b0;
  logic [11:0] addr = OFS_STAT;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         irq, wrst;

  always #4 clk = ~clk;

  wdg_indep_top #(.CNT_W(12), .SYNC_TICKS(SYNC), .RST_CYCLES(RSTC), .REVISION(REV)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_tick(tick), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .early_irq(irq), .wdg_rst(wrst));

  int errs = 0, checks = 0, phase = 0, cyc = 0;
  int rise_cnt = 0, last_rise = 0, prev_rise = 0, hi_len = 0, last_hi = 0;
  bit prev_wrst = 0;

  // behavioural reference state
  int m_run, m_unl, m_refp, m_cnt, m_pre, m_flag, m_pulse;
  int m_psh, m_peff, m_pp, m_ps;
  int m_rsh, m_reff, m_rp, m_rs;
  int m_esh_en, m_esh_c, m_eeff_en, m_eeff_c, m_ep, m_es;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int m_read(input logic [11:0] a);
    case (a)
      OFS_PRE:  return m_psh;
      OFS_RLD:  return m_rsh;
      OFS_STAT: return m_pp | (m_rp << 1) | (m_ep << 3) | (m_run << 8) | (m_flag << 15);
      OFS_EWC:  return (m_esh_en << 15) | m_esh_c;
      OFS_VER:  return int'(REV);
      default:  return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    phase++;
    tick = (phase % 2 == 0);
  end

  always @(posedge clk) begin : model
    int req, clr, hit, expd, lim, pc, d, k;
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_unl = 0; m_refp = 0; m_cnt = 4095; m_pre = 0; m_flag = 0; m_pulse = 0;
      m_psh = 0; m_peff = 0; m_pp = 0; m_ps = 0;
      m_rsh = 4095; m_reff = 4095; m_rp = 0; m_rs = 0;
      m_esh_en = 0; m_esh_c = 0; m_eeff_en = 0; m_eeff_c = 0; m_ep = 0; m_es = 0;
    end else begin
      req = 0; clr = 0; hit = 0; expd = 0;
      d = int'(wdata);
      k = 0;
      if (sel && wr && addr == OFS_KEY) begin
        k = 1;
        if (wdata == 32'h0000CCCC || wdata == 32'h0000AAAA) req = 1;
      end
      if (sel && wr && addr == OFS_EWC) begin
        if (m_unl && !m_ep && ((d & 'hFFF) != m_esh_c)) req = 1;
        if (d[14]) clr = 1;
      end
      if (sel && wr && addr == OFS_ICR && d[15]) clr = 1;
      // counter side, on old settings
      pc = (m_peff > 8) ? 8 : m_peff;
      lim = (4 << pc) - 1;
      if (tick) begin
        if (m_refp || req) begin
          m_cnt = m_reff; m_pre = 0;
        end else if (m_run) begin
          if (m_pre >= lim) begin
            m_pre = 0;
            if (m_cnt == 0) begin expd = 1; m_cnt = m_reff; end
            else begin
              if (m_eeff_en && (m_cnt - 1) == m_eeff_c) hit = 1;
              m_cnt = m_cnt - 1;
            end
          end else m_pre = m_pre + 1;
        end
        m_refp = 0;
      end else if (req) m_refp = 1;
      if (expd) m_pulse = RSTC; else if (m_pulse > 0) m_pulse--;
      // transfers landing
      if (tick && m_pp) begin if (m_ps == SYNC-1) begin m_peff = m_psh; m_pp = 0; m_ps = 0; end else m_ps++; end
      if (tick && m_rp) begin if (m_rs == SYNC-1) begin m_reff = m_rsh; m_rp = 0; m_rs = 0; end else m_rs++; end
      if (tick && m_ep) begin
        if (m_es == SYNC-1) begin m_eeff_en = m_esh_en; m_eeff_c = m_esh_c; m_ep = 0; m_es = 0; end
        else m_es++;
      end
      // bus side writes
      if (sel && wr && m_unl) begin
        if (addr == OFS_PRE && !m_pp && !(tick && 0)) begin
          if (m_pp == 0) begin m_psh = d & 'hF; m_pp = 1; m_ps = 0; end
        end
        if (addr == OFS_RLD && m_rp == 0) begin m_rsh = d & 'hFFF; m_rp = 1; m_rs = 0; end
        if (addr == OFS_EWC && m_ep == 0) begin m_esh_en = d[15]; m_esh_c = d & 'hFFF; m_ep = 1; m_es = 0; end
      end
      if (k) begin
        m_unl = (wdata == 32'h00005555);
        if (wdata == 32'h0000CCCC) m_run = 1;
      end
      if (hit) m_flag = 1; else if (clr) m_flag = 0;
    end
  end

  // A write that lands in the same cycle a pending flag clears must see the old flag:
  // the model above tests the pending flag after landing, so guard with the pre-edge copy.
  // (Writes in this bench are never issued while a transfer is pending, except the R8 case,
  // which is issued right after the first write and well before the landing tick.)

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(irq == m_flag[0], "R9 early_irq", irq, m_flag);
      chk(wrst == (m_pulse != 0), "R5 wdg_rst", wrst, m_pulse != 0);
      if (sel && !wr)
        chk(rdata == m_read(addr), (addr == OFS_STAT) ? "R7 status" : "R12 readback",
            rdata, m_read(addr));
    end
  end

  always @(posedge clk) begin
    #3;
    if (wrst && !prev_wrst) begin
      prev_rise = last_rise; last_rise = cyc; rise_cnt++; hi_len = 0;
    end
    if (wrst) hi_len++;
    if (!wrst && prev_wrst) last_hi = hi_len;
    prev_wrst = wrst;
  end

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = OFS_STAT; wdata = '0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); addr = a;
    @(posedge clk); #1 v = rdata;
    @(negedge clk); addr = OFS_STAT;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic period_check(input int exp_cycles, input string tag);
    int target;
    target = rise_cnt + 3;
    while (rise_cnt < target) @(negedge clk);
    chk(last_rise - prev_rise == exp_cycles, tag, last_rise - prev_rise, exp_cycles);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd_reg(OFS_STAT, v); chk(v == 0, "R1 status", v, 0);
    rd_reg(OFS_PRE, v);  chk(v == 0, "R1 prescaler", v, 0);
    rd_reg(OFS_RLD, v);  chk(v == 32'hFFF, "R1 reload", v, 32'hFFF);
    rd_reg(OFS_EWC, v);  chk(v == 0, "R1 early ctrl", v, 0);
    chk(!wrst && !irq, "R1 outputs", {wrst, irq}, 0);
    // R12 layout
    rd_reg(OFS_VER, v);  chk(v == 32'h40, "R12 version", v, 32'h40);
    rd_reg(OFS_KEY, v);  chk(v == 0, "R12 key reads 0", v, 0);
    rd_reg(OFS_ICR, v);  chk(v == 0, "R12 clear reads 0", v, 0);
    // R2 locked writes ignored
    wr_reg(OFS_PRE, 3);
    rd_reg(OFS_PRE, v);  chk(v == 0, "R2 locked prescaler", v, 0);
    rd_reg(OFS_STAT, v); chk(v == 0, "R2 no pending when locked", v, 0);
    // R7 / R8
    wr_reg(OFS_KEY, 32'h5555);
    wr_reg(OFS_RLD, 3);
    wr_reg(OFS_RLD, 7);
    rd_reg(OFS_RLD, v);  chk(v == 3, "R8 busy write ignored", v, 3);
    idle(10);
    rd_reg(OFS_STAT, v); chk(v[1] == 0, "R7 pending cleared", v[1], 0);
    wr_reg(OFS_PRE, 0);
    rd_reg(OFS_STAT, v); chk(v[0] == 1 && v[2] == 0, "R7 pending set", v, 1);
    idle(10);
    // R3 start
    wr_reg(OFS_KEY, 32'hCCCC);
    rd_reg(OFS_STAT, v); chk(v[8] == 1, "R3 running", v[8], 1);
    wr_reg(OFS_RLD, 9);
    rd_reg(OFS_RLD, v);  chk(v == 3, "R2 start key locks", v, 3);
    // R5 / R4 code 0: (3+1)*4 ticks * 2 clocks
    period_check(32, "R5 period code0");
    idle(8);
    chk(last_hi == RSTC, "R5 pulse width", last_hi, RSTC);
    // R3 cannot stop
    wr_reg(OFS_KEY, 32'h0);
    wr_reg(OFS_KEY, 32'h1234);
    rd_reg(OFS_STAT, v); chk(v[8] == 1, "R3 still running", v[8], 1);
    // R6 reload key keeps it quiet
    wr_reg(OFS_KEY, 32'hAAAA);
    idle(6);
    base = rise_cnt;
    for (int i = 0; i < 20; i++) begin
      wr_reg(OFS_KEY, 32'hAAAA);
      idle(8);
    end
    chk(rise_cnt == base, "R6 refresh prevents reset", rise_cnt - base, 0);
    // R4 other codes
    wr_reg(OFS_KEY, 32'h5555);
    wr_reg(OFS_PRE, 1);
    period_check(64, "R4 period code1");
    wr_reg(OFS_PRE, 15);
    period_check(8192, "R4 clamped code");
    // early warning setup
    wr_reg(OFS_PRE, 0);
    wr_reg(OFS_RLD, 7);
    idle(10);
    wr_reg(OFS_EWC, 32'h8002);
    idle(10);
    // R9
    for (int i = 0; i < 300 && !irq; i++) @(negedge clk);
    chk(irq == 1, "R9 early flag raised", irq, 1);
    idle(100);
    rd_reg(OFS_STAT, v); chk(v[15] == 1, "R9 flag sticky", v[15], 1);
    // R10 clear via clear register while locked
    wr_reg(OFS_KEY, 32'h0);
    wr_reg(OFS_ICR, 32'h8000);
    chk(irq == 0, "R10 clear register", irq, 0);
    for (int i = 0; i < 300 && !irq; i++) @(negedge clk);
    chk(irq == 1, "R9 flag raised again", irq, 1);
    wr_reg(OFS_EWC, 32'h4000);
    chk(irq == 0, "R10 clear bit in control", irq, 0);
    rd_reg(OFS_EWC, v);  chk(v == 32'h8002, "R10 locked fields kept", v, 32'h8002);
    // R11 compare change refreshes
    wr_reg(OFS_KEY, 32'h5555);
    wr_reg(OFS_EWC, 32'h8003);
    idle(6);
    base = rise_cnt;
    for (int i = 0; i < 10; i++) begin
      wr_reg(OFS_EWC, (i % 2 == 1) ? 32'h8003 : 32'h8002);
      idle(10);
    end
    chk(rise_cnt == base, "R11 compare change refreshes", rise_cnt - base, 0);
    base = rise_cnt;
    for (int i = 0; i < 12; i++) begin
      wr_reg(OFS_EWC, 32'h8003);
      idle(10);
    end
    chk(rise_cnt > base, "R11 same compare no refresh", rise_cnt - base, 1);
    idle(4);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule